// File: doc/BRIEF.md
# Associative Translation Buffer with Maintenance Counters

A small, fully associative translation buffer. It maps a virtual page and an address-space identifier to a physical frame. Each slot holds a valid bit, a virtual page number, an identifier, a frame number and a page-size bit. The size bit selects a 4 KiB or a 64 KiB page. A lookup port returns hit and frame one cycle after the request. An insert port accepts translations found by an external table walker. The newest translation always enters slot 0, and every older one moves down a slot.

A maintenance port runs four invalidate commands, each in one cycle: everything, by address, by identifier, and by both. A bank of saturating event counters records the following:

- hits and misses for each access class;
- inserts;
- invalidate commands of each kind;
- the number of entries each invalidate actually removed.

A combinational read port exposes these counters and their derived sums to a monitor.

Top module: `xlat_buf`

## Requirements
- R1: A lookup presented with `lk_valid` gives `rsp_valid`=1 exactly one cycle later. It hits when some slot is valid, has an equal identifier and an equal page. On a hit `rsp_pfn` is that slot's frame; on a miss `rsp_hit`=0 and `rsp_pfn`=0.
- R2: With `ins_big`=0 (4 KiB) the page compare uses address bits [31:12]. With `ins_big`=1 (64 KiB) it uses bits [31:16], and the returned frame takes its low 4 bits from address bits [15:12].
- R3: An accepted insert writes slot 0 and moves each slot i-1 to slot i. The entry in the last slot (slot 7 by default) is lost.
- R4: When several slots match a lookup, the lowest-numbered slot wins. This is the most recently inserted one.
- R5: Maintenance code 0 invalidates every slot.
- R6: Code 1 clears every valid slot whose page matches the address, whatever its identifier. Code 2 clears every valid slot with an equal identifier. Code 3 clears every slot that matches both, however many there are.
- R7: `mnt_done` pulses one cycle after each command. The command's own counter (address 7 for code 0, 8 for code 1, 9 for code 2, 10 for code 3) adds one even when nothing matched.
- R8: Counter 11 adds the number of slots that were valid and were cleared by the command.
- R9: Lookups are counted by class: fetch hit/miss at addresses 0/1, read at 2/3, write at 4/5. `lk_fetch` outranks `lk_write`; an access with neither flag set is a read.
- R10: Reading addresses 12, 13 and 14 gives the fetch, read and write totals (hits plus misses). Addresses 15, 16 and 17 give total hits, total misses and total lookups. Any other address reads 0.
- R11: Counter 6 adds one for every accepted insert.
- R12: Every counter and every derived sum stops at its all-ones value instead of wrapping.
- R13: An insert issued in the same cycle as a maintenance command is dropped and not counted. A lookup issued in the same cycle as an update sees the table as it stood before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup identifier |
| lk_fetch | input | 1 | Access is an instruction fetch |
| lk_write | input | 1 | Access is a data write |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | PA_W-12 | Translated frame number |
| ins_valid | input | 1 | Insert request |
| ins_va | input | VA_W | Virtual address of new entry |
| ins_asid | input | ASID_W | Identifier of new entry |
| ins_pfn | input | PA_W-12 | Frame of new entry |
| ins_big | input | 1 | New entry is a 64 KiB page |
| mnt_valid | input | 1 | Maintenance command |
| mnt_op | input | 2 | 0 all, 1 address, 2 identifier, 3 both |
| mnt_va | input | VA_W | Command address |
| mnt_asid | input | ASID_W | Command identifier |
| mnt_done | output | 1 | Command completion pulse |
| rd_addr | input | 5 | Counter select |
| rd_data | output | CNT_W | Selected counter value |

## Verification
The bench fills the table past its depth, to show that the oldest entry falls out while its neighbour survives. A shift off by one would lose the wrong slot or keep a stale one. It creates duplicate translations to check that the newest wins, and runs an address-plus-identifier invalidate over two matches to catch a design that clears only the first. It also runs an invalidate with no match and an invalidate of an empty table, so a design that skips the command count or counts invalid slots as flushed is caught. The remaining directed cases cover:

- a fetch flagged also as a write;
- an insert that collides with a command;
- a lookup in the same cycle as an insert;
- a 3-bit counter instance that would wrap instead of holding at 7.

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int ASID_W    = 8,
  parameter int CNT_W     = 32,
  parameter int PG_SHIFT  = 12,
  parameter int BIG_SHIFT = 16,
  localparam int VPN_W    = VA_W - PG_SHIFT,
  localparam int PFN_W    = PA_W - PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_fetch,
  input  logic              lk_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  input  logic              ins_valid,
  input  logic [VA_W-1:0]   ins_va,
  input  logic [ASID_W-1:0] ins_asid,
  input  logic [PFN_W-1:0]  ins_pfn,
  input  logic              ins_big,
  input  logic              mnt_valid,
  input  logic [1:0]        mnt_op,
  input  logic [VA_W-1:0]   mnt_va,
  input  logic [ASID_W-1:0] mnt_asid,
  output logic              mnt_done,
  input  logic [4:0]        rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int SUB_W = BIG_SHIFT - PG_SHIFT;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int EW    = CNT_W + IDX_W + 3;
  localparam int NCNT  = 12;
  localparam int C_INS = 6, C_FL0 = 7, C_FLE = 11;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   vpn  [ENTRIES];
  logic [ASID_W-1:0]  asid [ENTRIES];
  logic [PFN_W-1:0]   pfn  [ENTRIES];
  logic [ENTRIES-1:0] big;
  logic [CNT_W-1:0]   cnt  [NCNT];

  logic [ENTRIES-1:0] lk_m, fl_m;
  logic               lk_hit;
  logic [PFN_W-1:0]   lk_pfn;
  logic [IDX_W:0]     inc [NCNT];
  logic [IDX_W:0]     n_clr;

  function automatic logic pg_eq(input logic [VPN_W-1:0] e, input logic b, input logic [VA_W-1:0] va);
    logic [VPN_W-1:0] mask;
    mask = b ? ~VPN_W'((1 << SUB_W) - 1) : '1;
    return ((e ^ va[VA_W-1:PG_SHIFT]) & mask) == '0;
  endfunction

  function automatic logic [CNT_W-1:0] sat(input logic [EW-1:0] s);
    return (s > EW'(CMAX)) ? CMAX : s[CNT_W-1:0];
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    logic pm;
    assign lk_m[i] = vld[i] && asid[i] == lk_asid && pg_eq(vpn[i], big[i], lk_va);
    assign pm      = pg_eq(vpn[i], big[i], mnt_va);
    always_comb begin
      case (mnt_op)
        2'd0:    fl_m[i] = vld[i];
        2'd1:    fl_m[i] = vld[i] && pm;
        2'd2:    fl_m[i] = vld[i] && asid[i] == mnt_asid;
        default: fl_m[i] = vld[i] && pm && asid[i] == mnt_asid;
      endcase
    end
  end

  always_comb begin
    lk_pfn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (lk_m[i]) lk_pfn = big[i] ? {pfn[i][PFN_W-1:SUB_W], lk_va[BIG_SHIFT-1:PG_SHIFT]} : pfn[i];
  end
  assign lk_hit = |lk_m;
  assign n_clr  = (IDX_W+1)'($countones(fl_m));

  always_comb begin
    for (int k = 0; k < NCNT; k++) inc[k] = '0;
    if (lk_valid) inc[(lk_fetch ? 0 : lk_write ? 4 : 2) + (lk_hit ? 0 : 1)] = 1;
    if (mnt_valid) begin
      inc[C_FL0 + int'(mnt_op)] = 1;
      inc[C_FLE] = n_clr;
    end else if (ins_valid) inc[C_INS] = 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pfn   <= '0;
      mnt_done  <= 1'b0;
      for (int k = 0; k < NCNT; k++) cnt[k] <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_hit;
      rsp_pfn   <= lk_valid ? lk_pfn : '0;
      mnt_done  <= mnt_valid;
      for (int k = 0; k < NCNT; k++) cnt[k] <= sat(EW'(cnt[k]) + EW'(inc[k]));
      if (mnt_valid) vld <= vld & ~fl_m;
      else if (ins_valid) vld <= {vld[ENTRIES-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid && !mnt_valid) begin
      for (int i = ENTRIES - 1; i > 0; i--) begin
        vpn[i]  <= vpn[i-1];
        asid[i] <= asid[i-1];
        pfn[i]  <= pfn[i-1];
        big[i]  <= big[i-1];
      end
      vpn[0]  <= ins_va[VA_W-1:PG_SHIFT];
      asid[0] <= ins_asid;
      pfn[0]  <= ins_pfn;
      big[0]  <= ins_big;
    end
  end

  always_comb begin
    case (rd_addr)
      5'd12:   rd_data = sat(EW'(cnt[0]) + EW'(cnt[1]));
      5'd13:   rd_data = sat(EW'(cnt[2]) + EW'(cnt[3]));
      5'd14:   rd_data = sat(EW'(cnt[4]) + EW'(cnt[5]));
      5'd15:   rd_data = sat(EW'(cnt[0]) + EW'(cnt[2]) + EW'(cnt[4]));
      5'd16:   rd_data = sat(EW'(cnt[1]) + EW'(cnt[3]) + EW'(cnt[5]));
      5'd17:   rd_data = sat(EW'(cnt[0]) + EW'(cnt[1]) + EW'(cnt[2]) + EW'(cnt[3]) + EW'(cnt[4]) + EW'(cnt[5]));
      default: rd_data = (int'(rd_addr) < NCNT) ? cnt[rd_addr] : '0;
    endcase
  end

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> rsp_valid);
  p_rsp_only_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n) rsp_hit |-> rsp_valid && $past(lk_valid));
  p_insert_slot0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !mnt_valid |=> vld[0] && vpn[0] == $past(ins_va[VA_W-1:PG_SHIFT]) && pfn[0] == $past(ins_pfn));
  p_shift_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !mnt_valid |=> vld[ENTRIES-1:1] == $past(vld[ENTRIES-2:0]));
  p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n) mnt_valid && mnt_op == 2'd0 |=> vld == '0);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) mnt_done |-> $past(mnt_valid));
  p_insert_dropped_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_valid |=> $stable(cnt[C_INS]));
  p_no_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n) cnt[C_FLE] >= $past(cnt[C_FLE]));
endmodule

// File: tb/xlat_buf_tb_top.sv
module xlat_buf_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic        fetch;
    logic        write;
    logic        hit;
    logic [19:0] pfn;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0001_2ABC, 8'd5, 1'b1, 1'b0, 1'b1, 20'hAAAAA},
    '{32'h0001_2004, 8'd7, 1'b0, 1'b1, 1'b1, 20'hCCCCC},
    '{32'h0034_7123, 8'd5, 1'b0, 1'b0, 1'b1, 20'hBBBB7},
    '{32'h0034_7123, 8'd7, 1'b0, 1'b0, 1'b0, 20'h00000},
    '{32'h0001_3000, 8'd5, 1'b1, 1'b1, 1'b0, 20'h00000},
    '{32'h0035_0000, 8'd5, 1'b0, 1'b1, 1'b0, 20'h00000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_fetch = 0, lk_write = 0, ins_valid = 0, ins_big = 0, mnt_valid = 0;
  logic [31:0] lk_va = 0, ins_va = 0, mnt_va = 0;
  logic [7:0]  lk_asid = 0, ins_asid = 0, mnt_asid = 0;
  logic [19:0] ins_pfn = 0;
  logic [1:0]  mnt_op = 0;
  logic [4:0]  rd_addr = 0;
  logic        rsp_valid, rsp_hit, mnt_done, s_rsp_valid, s_rsp_hit, s_mnt_done;
  logic [19:0] rsp_pfn, s_rsp_pfn;
  logic [31:0] rd_data;
  logic [2:0]  s_rd_data;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_buf dut_i (.clk, .rst_n, .lk_valid, .lk_va, .lk_asid, .lk_fetch, .lk_write,
    .rsp_valid, .rsp_hit, .rsp_pfn, .ins_valid, .ins_va, .ins_asid, .ins_pfn, .ins_big,
    .mnt_valid, .mnt_op, .mnt_va, .mnt_asid, .mnt_done, .rd_addr, .rd_data);

  xlat_buf #(.CNT_W(3)) dut_sat_i (.clk, .rst_n, .lk_valid, .lk_va, .lk_asid, .lk_fetch, .lk_write,
    .rsp_valid(s_rsp_valid), .rsp_hit(s_rsp_hit), .rsp_pfn(s_rsp_pfn), .ins_valid, .ins_va,
    .ins_asid, .ins_pfn, .ins_big, .mnt_valid, .mnt_op, .mnt_va, .mnt_asid,
    .mnt_done(s_mnt_done), .rd_addr, .rd_data(s_rd_data));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] a, input bit f, input bit w,
                        input bit eh, input logic [19:0] ep, input string req);
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_asid = a; lk_fetch = f; lk_write = w;
    @(negedge clk);
    lk_valid = 0; lk_fetch = 0; lk_write = 0;
    chk(rsp_valid === 1'b1 && rsp_hit === eh && rsp_pfn === ep, req,
        {rsp_valid, rsp_hit, rsp_pfn}, {1'b1, eh, ep});
  endtask

  task automatic insert(input logic [31:0] va, input logic [7:0] a, input logic [19:0] p, input bit b);
    @(negedge clk);
    ins_valid = 1; ins_va = va; ins_asid = a; ins_pfn = p; ins_big = b;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic maint(input logic [1:0] op, input logic [31:0] va, input logic [7:0] a, input string req);
    @(negedge clk);
    mnt_valid = 1; mnt_op = op; mnt_va = va; mnt_asid = a;
    @(negedge clk);
    mnt_valid = 0;
    chk(mnt_done === 1'b1, req, mnt_done, 1);
  endtask

  task automatic rdc(input int addr, input logic [31:0] exp, input string req);
    rd_addr = 5'(addr);
    #1;
    chk(rd_data === exp, req, rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rsp_valid === 1'b0 && mnt_done === 1'b0, "R1 reset", {rsp_valid, mnt_done}, 0);
    rdc(6, 0, "R11 reset"); rdc(11, 0, "R8 reset"); rdc(17, 0, "R10 reset");

    insert(32'h0001_2000, 8'd5, 20'hAAAAA, 1'b0);
    insert(32'h0034_0000, 8'd5, 20'hBBBB0, 1'b1);
    insert(32'h0001_2000, 8'd7, 20'hCCCCC, 1'b0);
    for (int i = 0; i < 6; i++)
      lookup(VECS[i].va, VECS[i].asid, VECS[i].fetch, VECS[i].write, VECS[i].hit, VECS[i].pfn, "R1 R2 R9 vector");

    insert(32'h0001_2000, 8'd5, 20'h11111, 1'b0);
    lookup(32'h0001_2000, 8'd5, 0, 0, 1, 20'h11111, "R4 newest wins");
    maint(2'd3, 32'h0001_2FFF, 8'd5, "R7 done both");
    rdc(11, 2, "R6 both clears all matches R8");
    lookup(32'h0001_2000, 8'd5, 0, 0, 0, 0, "R6 both cleared");
    lookup(32'h0001_2000, 8'd7, 0, 0, 1, 20'hCCCCC, "R6 other asid kept");
    maint(2'd1, 32'h9000_0000, 8'd0, "R7 done no match");
    rdc(8, 1, "R7 counts empty command"); rdc(11, 2, "R8 no match adds none");
    maint(2'd1, 32'h0001_2000, 8'd0, "R7 done va");
    rdc(11, 3, "R8 by va");
    lookup(32'h0001_2000, 8'd7, 0, 0, 0, 0, "R6 by va any asid");
    maint(2'd2, 32'h0, 8'd5, "R7 done asid");
    rdc(11, 4, "R8 by asid");
    lookup(32'h0034_7123, 8'd5, 0, 0, 0, 0, "R6 by asid");

    for (int i = 0; i < 9; i++) insert(32'h0010_0000 + 32'(i) * 32'h1000, 8'd1, 20'h100 + 20'(i), 1'b0);
    lookup(32'h0010_0000, 8'd1, 1, 0, 0, 0, "R3 oldest discarded");
    lookup(32'h0010_1000, 8'd1, 1, 0, 1, 20'h101, "R3 neighbour kept");
    lookup(32'h0010_8000, 8'd1, 1, 0, 1, 20'h108, "R3 newest present");
    maint(2'd0, 32'h0, 8'd0, "R7 done all");
    rdc(11, 12, "R8 all counts eight");
    lookup(32'h0010_8000, 8'd1, 1, 0, 0, 0, "R5 all cleared");
    maint(2'd0, 32'h0, 8'd0, "R7 done all empty");
    rdc(11, 12, "R8 empty table adds none");

    @(negedge clk);
    mnt_valid = 1; mnt_op = 2'd0; ins_valid = 1; ins_va = 32'h0020_0000; ins_asid = 8'd2; ins_pfn = 20'h22222; ins_big = 0;
    @(negedge clk);
    mnt_valid = 0; ins_valid = 0;
    lookup(32'h0020_0000, 8'd2, 1, 0, 0, 0, "R13 insert dropped");

    @(negedge clk);
    ins_valid = 1; ins_va = 32'h0030_0000; ins_asid = 8'd3; ins_pfn = 20'h33333;
    lk_valid = 1; lk_va = 32'h0030_0000; lk_asid = 8'd3;
    @(negedge clk);
    ins_valid = 0; lk_valid = 0;
    chk(rsp_hit === 1'b0, "R13 lookup sees old table", rsp_hit, 0);
    lookup(32'h0030_0000, 8'd3, 0, 0, 1, 20'h33333, "R13 insert then visible");

    rdc(0, 3, "R9 fetch hit"); rdc(1, 4, "R9 fetch miss");
    rdc(2, 4, "R9 read hit");  rdc(3, 5, "R9 read miss");
    rdc(4, 1, "R9 write hit"); rdc(5, 1, "R9 write miss");
    rdc(6, 14, "R11 inserts");
    rdc(7, 3, "R7 all cmds"); rdc(8, 2, "R7 va cmds"); rdc(9, 1, "R7 asid cmds"); rdc(10, 1, "R7 both cmds");
    rdc(12, 7, "R10 fetch total"); rdc(13, 9, "R10 read total"); rdc(14, 2, "R10 write total");
    rdc(15, 8, "R10 hits"); rdc(16, 10, "R10 misses"); rdc(17, 18, "R10 lookups"); rdc(20, 0, "R10 unused");

    rd_addr = 5'd6;  #1; chk(s_rd_data === 3'd7, "R12 insert saturates", s_rd_data, 7);
    rd_addr = 5'd11; #1; chk(s_rd_data === 3'd7, "R12 flushed saturates", s_rd_data, 7);
    rd_addr = 5'd17; #1; chk(s_rd_data === 3'd7, "R12 sum saturates", s_rd_data, 7);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule